// File: doc/BRIEF.md
# DDR4 Power-Up Initialization Sequencer

This block brings a DDR4 memory device from the point where its supplies are stable up to the moment it can accept normal traffic. It drives the device reset line, the clock enable, the on-die termination control and the test-mode pin. It also produces a command stream on a small encoded bus. Each wait is a parameter counted in controller clock cycles. The sequencer holds reset, waits with clock enable low, then raises clock enable. After that it writes the seven mode registers in a fixed order, issues a long ZQ calibration, and raises a done level once both the calibration interval and the DLL lock interval have run out.

The mode-register contents come from a flat input vector, one 17-bit slice per register. A slice is sampled in the cycle before its write goes out, so the value on the bus is always the current one. A synchronous start pulse restarts the whole sequence from the reset phase, whatever state the block is in. Done then stays high until the next start.

Top module: `ddr4_init_seq`

## Requirements
- R1: After reset or a start pulse, `mem_reset_n` is low for exactly `T_RST_LOW` cycles and then goes high.
- R2: `mem_cke` stays low for `T_CKE_WAIT` cycles after `mem_reset_n` rises, then stays high until the next start. `mem_ten` is low at all times.
- R3: The first mode-register write appears exactly `T_XPR` cycles after `mem_cke` rises.
- R4: Seven writes follow at a spacing of exactly `T_MRD` cycles. They target registers 3, 6, 5, 4, 2, 1, 0 in that order, so the DLL-enable write to register 1 comes before the DLL-reset write to register 0. `mr_sel` carries the register number. `mr_data` carries bits `[r*17 +: 17]` of `mr_vals` as they stood in the cycle before the write.
- R5: ZQCL is issued exactly `T_MOD` cycles after the last mode-register write.
- R6: `init_done` rises at whichever comes later: `T_ZQINIT` cycles after ZQCL, or `T_DLLK` cycles after the register-0 write. It then stays high until the next start.
- R7: The command codes are DES=0, MRS=1 and ZQCL=2. Every cycle without a real command carries DES with `mr_sel` and `mr_data` zero.
- R8: While `mem_reset_n` is low, the block reads the RTT_NOM field, bits 10:8 of the register-1 slice. If that field is non-zero, `mem_odt` is low. Otherwise `mem_odt` takes the `ODT_IDLE` level. Changes to the field after reset release have no effect on `mem_odt` until the next restart.
- R9: Synchronous reset, and also a start pulse in any state, return the outputs to the reset phase: reset low, clock enable low, DES, done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Synchronous restart pulse |
| mr_vals | input | 119 | Mode-register contents, register r at bits r*17 +: 17 |
| mem_reset_n | output | 1 | Device reset, active low |
| mem_cke | output | 1 | Device clock enable |
| mem_odt | output | 1 | Device termination control |
| mem_ten | output | 1 | Device test-mode enable, held low |
| cmd | output | 2 | Command code: DES, MRS or ZQCL |
| mr_sel | output | 3 | Target mode-register number |
| mr_data | output | 17 | Mode-register payload |
| init_done | output | 1 | Initialization complete level |

## Verification
The hardest case to reach is the exit from the final wait. Done must follow whichever of the two independent intervals ends last. At the ports, only the moment done rises shows which interval was binding. The bench therefore runs two instances side by side on the same stimulus. One instance is configured so that DLL lock is the later limit, and the other so that ZQ calibration is. Random register contents, random RTT_NOM settings, restarts at random points, and a flip of the RTT_NOM field after reset release exercise the sampling and freezing rules cycle by cycle.

// File: rtl/ddr4_init_pkg.sv
package ddr4_init_pkg;

  localparam int MR_COUNT = 7;
  localparam int MR_W     = 17;
  localparam int SEL_W    = 3;

  typedef enum logic [1:0] {
    CMD_DES  = 2'd0,
    CMD_MRS  = 2'd1,
    CMD_ZQCL = 2'd2
  } cmd_e;

  typedef enum logic [3:0] {
    S_RST, S_CKE, S_XPR, S_MRS, S_GAP, S_MOD, S_ZQ, S_ZQI, S_DONE
  } st_e;

  // write position -> register number; register 1 precedes register 0
  function automatic logic [SEL_W-1:0] mr_at(input logic [SEL_W-1:0] pos);
    case (pos)
      3'd0:    return 3'd3;
      3'd1:    return 3'd6;
      3'd2:    return 3'd5;
      3'd3:    return 3'd4;
      3'd4:    return 3'd2;
      3'd5:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
  parameter int CW      = 8,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= CW'(RST_VAL);
    else if (load_i)      cnt <= val_i;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);

  // every wait interval shrinks by one per cycle (R1, R2, R3)
  p_count_down_r1: assert property (@(posedge clk) disable iff (rst)
    (!load_i && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  p_load_takes_r3: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt == $past(val_i)));

endmodule

// File: rtl/init_mr_select.sv
module init_mr_select
  import ddr4_init_pkg::*;
#(
  parameter int RTT_LO = 8,
  parameter int RTT_HI = 10
) (
  input  logic [SEL_W-1:0]          pos_i,
  input  logic [MR_COUNT*MR_W-1:0]  mr_vals_i,
  output logic [SEL_W-1:0]          sel_o,
  output logic [MR_W-1:0]           data_o,
  output logic                      rtt_on_o
);

  logic [MR_W-1:0] regs [MR_COUNT];

  for (genvar g = 0; g < MR_COUNT; g++) begin : g_slice
    assign regs[g] = mr_vals_i[g*MR_W +: MR_W];
  end

  assign sel_o    = mr_at(pos_i);
  assign data_o   = regs[sel_o];
  assign rtt_on_o = |regs[1][RTT_HI:RTT_LO];

endmodule

// File: rtl/ddr4_init_seq.sv
module ddr4_init_seq
  import ddr4_init_pkg::*;
#(
  parameter int   T_RST_LOW  = 1000,
  parameter int   T_CKE_WAIT = 400000,
  parameter int   T_XPR      = 300,
  parameter int   T_MRD      = 8,
  parameter int   T_MOD      = 24,
  parameter int   T_DLLK     = 768,
  parameter int   T_ZQINIT   = 1024,
  parameter logic ODT_IDLE   = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [MR_COUNT*MR_W-1:0]  mr_vals,
  output logic                      mem_reset_n,
  output logic                      mem_cke,
  output logic                      mem_odt,
  output logic                      mem_ten,
  output logic [1:0]                cmd,
  output logic [SEL_W-1:0]          mr_sel,
  output logic [MR_W-1:0]           mr_data,
  output logic                      init_done
);

  localparam int T_MAX  = max2(max2(max2(T_RST_LOW, T_CKE_WAIT), max2(T_XPR, T_MRD)),
                               max2(max2(T_MOD, T_DLLK), T_ZQINIT));
  localparam int CW     = $clog2(T_MAX + 1);
  localparam int GAP_SAT = max2(T_MRD, T_MOD);
  localparam logic [SEL_W-1:0] LAST_POS = SEL_W'(MR_COUNT - 1);

  st_e              state, nxt;
  logic [SEL_W-1:0] pos, nxt_pos;
  logic             ld, dll_ld, tz, dll_z, rtt_on;
  logic [CW-1:0]    ldv;
  logic [SEL_W-1:0] sel_n;
  logic [MR_W-1:0]  data_n;

  init_wait_timer #(.CW(CW), .RST_VAL(T_RST_LOW - 1)) u_step_tmr (
    .clk(clk), .rst(rst), .load_i(ld), .val_i(ldv), .zero_o(tz)
  );

  init_wait_timer #(.CW(CW), .RST_VAL(0)) u_dll_tmr (
    .clk(clk), .rst(rst), .load_i(dll_ld), .val_i(CW'(T_DLLK - 2)), .zero_o(dll_z)
  );

  init_mr_select u_mr_sel (
    .pos_i(nxt_pos), .mr_vals_i(mr_vals),
    .sel_o(sel_n), .data_o(data_n), .rtt_on_o(rtt_on)
  );

  always_comb begin
    nxt     = state;
    nxt_pos = pos;
    ld      = 1'b0;
    ldv     = '0;
    dll_ld  = 1'b0;
    if (start) begin
      nxt     = S_RST;
      nxt_pos = '0;
      ld      = 1'b1;
      ldv     = CW'(T_RST_LOW - 1);
    end else begin
      case (state)
        S_RST: if (tz) begin
          nxt = S_CKE; ld = 1'b1; ldv = CW'(T_CKE_WAIT - 1);
        end
        S_CKE: if (tz) begin
          nxt = S_XPR; ld = 1'b1; ldv = CW'(T_XPR - 1);
        end
        S_XPR: if (tz) begin
          nxt = S_MRS; nxt_pos = '0; ld = 1'b1; ldv = '0;
        end
        S_MRS: begin
          ld = 1'b1;
          if (pos == LAST_POS) begin
            nxt = S_MOD; ldv = CW'(T_MOD - 2); dll_ld = 1'b1;
          end else begin
            nxt = S_GAP; ldv = CW'(T_MRD - 2);
          end
        end
        S_GAP: if (tz) begin
          nxt = S_MRS; nxt_pos = pos + 3'd1; ld = 1'b1; ldv = '0;
        end
        S_MOD: if (tz) begin
          nxt = S_ZQ; ld = 1'b1; ldv = '0;
        end
        S_ZQ: begin
          nxt = S_ZQI; ld = 1'b1; ldv = CW'(T_ZQINIT - 2);
        end
        S_ZQI: if (tz && dll_z) nxt = S_DONE;
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_RST;
      pos         <= '0;
      mem_reset_n <= 1'b0;
      mem_cke     <= 1'b0;
      mem_odt     <= 1'b0;
      cmd         <= CMD_DES;
      mr_sel      <= '0;
      mr_data     <= '0;
      init_done   <= 1'b0;
    end else begin
      state       <= nxt;
      pos         <= nxt_pos;
      mem_reset_n <= (nxt != S_RST);
      mem_cke     <= !(nxt inside {S_RST, S_CKE});
      init_done   <= (nxt == S_DONE);
      if (nxt == S_MRS) begin
        cmd     <= CMD_MRS;
        mr_sel  <= sel_n;
        mr_data <= data_n;
      end else begin
        cmd     <= (nxt == S_ZQ) ? CMD_ZQCL : CMD_DES;
        mr_sel  <= '0;
        mr_data <= '0;
      end
      if (state == S_RST) mem_odt <= rtt_on ? 1'b0 : ODT_IDLE;
    end
  end

  assign mem_ten = 1'b0;

  // assertion support: cycles since the last MRS, saturating
  logic [CW-1:0] since_mrs;
  always_ff @(posedge clk) begin
    if (rst || start)              since_mrs <= CW'(GAP_SAT);
    else if (cmd == CMD_MRS)       since_mrs <= CW'(1);
    else if (since_mrs < CW'(GAP_SAT)) since_mrs <= since_mrs + 1'b1;
  end

  p_cke_after_reset_r2: assert property (@(posedge clk) disable iff (rst)
    !mem_reset_n |-> !mem_cke);

  p_cke_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_cke && !start) |=> mem_cke);

  p_mrs_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_MRS) |-> (since_mrs >= CW'(T_MRD)));

  p_zq_gap_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_ZQCL) |-> (since_mrs >= CW'(T_MOD)));

  p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (init_done && !start) |=> init_done);

  p_done_after_dll_r6: assert property (@(posedge clk) disable iff (rst)
    init_done |-> dll_z);

  p_cmd_needs_cke_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_DES) |-> mem_cke);

  p_odt_static_r8: assert property (@(posedge clk) disable iff (rst)
    mem_reset_n |=> $stable(mem_odt));

  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    start |=> (!mem_reset_n && !mem_cke && !init_done && cmd == CMD_DES));

endmodule

// File: tb/ddr4_init_seq_bench.sv
module ddr4_init_seq_bench;

  localparam int TR = 10, TC = 30, TX = 6, MRD = 4, MDL = 5;
  localparam int DA = 40, ZA = 12;   // DLL lock is the later limit
  localparam int DB = 8,  ZB = 30;   // ZQ calibration is the later limit
  localparam int LEN = 114;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [16:0] mrv [7];
  logic [7*17-1:0] mr_flat;
  int checks = 0, fails = 0;
  bit fin = 1'b0;

  always #5 clk = ~clk;

  always_comb for (int r = 0; r < 7; r++) mr_flat[r*17 +: 17] = mrv[r];

  logic rn_a, cke_a, odt_a, ten_a, dn_a, rn_b, cke_b, odt_b, ten_b, dn_b;
  logic [1:0] cmd_a, cmd_b;
  logic [2:0] sel_a, sel_b;
  logic [16:0] dat_a, dat_b;

  ddr4_init_seq #(.T_RST_LOW(TR), .T_CKE_WAIT(TC), .T_XPR(TX), .T_MRD(MRD),
                  .T_MOD(MDL), .T_DLLK(DA), .T_ZQINIT(ZA)) u_ddr4_init_seq (
    .clk(clk), .rst(rst), .start(start), .mr_vals(mr_flat),
    .mem_reset_n(rn_a), .mem_cke(cke_a), .mem_odt(odt_a), .mem_ten(ten_a),
    .cmd(cmd_a), .mr_sel(sel_a), .mr_data(dat_a), .init_done(dn_a));

  ddr4_init_seq #(.T_RST_LOW(TR), .T_CKE_WAIT(TC), .T_XPR(TX), .T_MRD(MRD),
                  .T_MOD(MDL), .T_DLLK(DB), .T_ZQINIT(ZB)) u_alt (
    .clk(clk), .rst(rst), .start(start), .mr_vals(mr_flat),
    .mem_reset_n(rn_b), .mem_cke(cke_b), .mem_odt(odt_b), .mem_ten(ten_b),
    .cmd(cmd_b), .mr_sel(sel_b), .mr_data(dat_b), .init_done(dn_b));

  function automatic int order_of(input int k);
    int tbl [7] = '{3, 6, 5, 4, 2, 1, 0};
    return tbl[k];
  endfunction

  task automatic cmp(input string nm, input string tag, input int t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s t=%0d actual=%0h expected=%0h", tag, nm, t, act, exp);
    end
  endtask

  task automatic check_dut(input string nm, input int t, input int dllk, input int zq,
                           input logic eodt, input logic rn, input logic cke, input logic odt,
                           input logic ten, input logic [1:0] c, input logic [2:0] s,
                           input logic [16:0] d, input logic dn);
    int b, m6, z, dd, k, ec, es, ed;
    string tag;
    b = TR + TC + TX; m6 = b + 6*MRD; z = m6 + MDL;
    dd = (z + zq > m6 + dllk) ? z + zq : m6 + dllk;
    ec = 0; es = 0; ed = 0; tag = "R7";
    if (t >= b && ((t - b) % MRD) == 0 && (t - b) / MRD < 7) begin
      k = (t - b) / MRD; ec = 1; es = order_of(k); ed = int'(mrv[es]);
      tag = (k == 0) ? "R3" : "R4";
    end else if (t == z) begin
      ec = 2; tag = "R5";
    end
    cmp({nm, ".reset_n"}, "R1", t, int'(rn), int'(t >= TR));
    cmp({nm, ".cke"}, "R2", t, int'(cke), int'(t >= TR + TC));
    cmp({nm, ".ten"}, "R2", t, int'(ten), 0);
    cmp({nm, ".cmd"}, tag, t, int'(c), ec);
    cmp({nm, ".sel"}, tag, t, int'(s), es);
    cmp({nm, ".data"}, tag, t, int'(d), ed);
    cmp({nm, ".done"}, "R6", t, int'(dn), int'(t >= dd));
    if (t >= TR) cmp({nm, ".odt"}, "R8", t, int'(odt), int'(eodt));
  endtask

  task automatic rand_mr(input bit rtt_en);
    for (int r = 0; r < 7; r++) mrv[r] = 17'($urandom);
    mrv[1][10:8] = rtt_en ? 3'($urandom_range(1, 7)) : 3'd0;
  endtask

  // len cycles checked; flip_t flips the RTT_NOM field after that cycle's check
  task automatic run_seq(input int len, input int flip_t, input bit from_reset);
    logic eodt;
    if (!from_reset) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    eodt = (|mrv[1][10:8]) ? 1'b0 : 1'b1;
    for (int t = 0; t < len; t++) begin
      if (t > 0) @(negedge clk);
      check_dut("a", t, DA, ZA, eodt, rn_a, cke_a, odt_a, ten_a, cmd_a, sel_a, dat_a, dn_a);
      check_dut("b", t, DB, ZB, eodt, rn_b, cke_b, odt_b, ten_b, cmd_b, sel_b, dat_b, dn_b);
      if (t == flip_t) mrv[1][10:8] = ~mrv[1][10:8];
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rand_mr(1'b1);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9: reset state visible right after reset release
    cmp("reset.reset_n", "R9", 0, int'(rn_a), 0);
    cmp("reset.cke", "R9", 0, int'(cke_a), 0);
    cmp("reset.cmd", "R9", 0, int'(cmd_a), 0);
    cmp("reset.done", "R9", 0, int'(dn_a), 0);
    run_seq(LEN, -1, 1'b1);
    // start while done, RTT_NOM off
    rand_mr(1'b0);
    run_seq(LEN, -1, 1'b0);
    // restart mid-sequence (R9), then a full run
    rand_mr(1'b1);
    run_seq(TR + TC + TX + 9, -1, 1'b0);
    run_seq(LEN, -1, 1'b0);
    // R8: RTT_NOM field changes after reset release, ODT must not follow
    rand_mr(1'b0);
    run_seq(LEN, TR + 3, 1'b0);
    rand_mr(1'b1);
    run_seq(LEN, TR + 1, 1'b0);
    for (int i = 0; i < 6; i++) begin
      rand_mr(1'($urandom));
      if ($urandom_range(0, 1) == 1) run_seq($urandom_range(1, LEN - 2), -1, 1'b0);
      run_seq(LEN, -1, 1'b0);
    end
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule